// File: doc/BRIEF.md
# Pixel Port Output Formatter

This block sits between a frame-buffer scan-out stream and a wide parallel video output port. Each pixel clock it takes one pixel, in raster order (left to right, top to bottom), together with the raster timing flags already produced upstream: blank, composite sync, vertical sync and field. It drives three 12-bit colour lanes and the same four timing flags. An optional luminance mode packs a 16-bit grey value redundantly across the three lanes. In this mode a receiver that reads only the top 8 bits of any lane still sees a valid monochrome image, and a receiver that reads all lanes can rebuild the full 16 bits.

The output latency depends on a pixel-rate band selected by a 2-bit code. Faster bands add more pipeline stages. In every band the blank flag leads the pixel lanes by exactly three clocks, so receiver control logic can prepare before active data arrives. Sync and field travel with blank, so their relation to the data does not depend on the band.

A small controller watches the band code. When the code changes, it drains the whole pipeline to the blanked condition. It does this by injecting blank records for a fixed number of sampling edges, and the pixel inputs are ignored during that interval. The controller has two named states. `ST_RUN` is the normal pass-through state. It moves to `ST_FLUSH` on the first edge where the band code differs from the held band. `ST_FLUSH` counts down and returns to `ST_RUN` after the last injected record.

Top module: `vdp_out_fmt`

## Requirements
- R1: In colour mode (`lum_mode_i`=0), `pix_i[35:24]` appears on `red_o`, `pix_i[23:12]` on `green_o` and `pix_i[11:0]` on `blue_o`, 4+E clock edges after the edge that samples it. E is the band's extra delay.
- R2: The band code sets E. Code 0 gives E=0, code 1 gives E=2, and codes 2 and 3 give E=3. `blank_o` shows the `blank_i` value sampled 1+E edges earlier.
- R3: In every band, `blank_o` and the pixel lanes belonging to the same input pixel are three clocks apart, with blank first.
- R4: In luminance mode (`lum_mode_i`=1), the 16-bit value is `pix_i[15:0]`. Its bits [15:4] go on both `red_o` and `green_o`.
- R5: In luminance mode, `blue_o[11:4]` carries luminance bits [15:8] and `blue_o[3:0]` carries luminance bits [3:0].
- R6: `csync_o`, `vsync_o` and `field_o` have the same latency as `blank_o` in every band. A field input held low, as for progressive formats, stays low at the output.
- R7: When the band code differs from the held band at a sampling edge in `ST_RUN`, the new code is taken at that edge. That edge and the next 6 edges (7 in total) load a blank record instead of the inputs: blank=1, syncs=0, field=0, pixel=0.
- R8: `rsv_sel_o` is always 2'b00.
- R9: While reset is applied and before the first edge after it, `blank_o`=1 and all other outputs are 0.
- R10: The band code may change only on an edge where `blank_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| band_i | input | 2 | Pixel-rate band code (0 low, 1 mid, 2 high, 3 treated as high) |
| lum_mode_i | input | 1 | 1 selects 16-bit luminance packing |
| pix_i | input | 36 | Input pixel {red, green, blue}; luminance in [15:0] |
| blank_i | input | 1 | Input blank flag, aligned with pix_i |
| csync_i | input | 1 | Input composite sync |
| vsync_i | input | 1 | Input vertical sync |
| field_i | input | 1 | Input field flag |
| red_o | output | 12 | Red lane |
| green_o | output | 12 | Green lane |
| blue_o | output | 12 | Blue lane |
| blank_o | output | 1 | Blank, three clocks ahead of the lanes |
| csync_o | output | 1 | Composite sync, aligned with blank_o |
| vsync_o | output | 1 | Vertical sync, aligned with blank_o |
| field_o | output | 1 | Field, aligned with blank_o |
| rsv_sel_o | output | 2 | Reserved selects, held low |

## Verification
The embedded properties check the following on every cycle: the three-clock gap between the tapped record and the pixel lanes, the lane duplication and split in luminance mode, blank injection during a flush, the flush counter range, and the rule that the band may change only during blank. Some behaviours need the bench's traffic to show them. These are the absolute latency of each band, including code 3, the exact seven-edge length of the drain after a band change, the fact that active pixels offered during that drain never appear, and the reset condition of the port. The bench follows a raster-like stream through all bands in both packing modes and compares every output on every clock.

// File: rtl/vdp_pkg.sv
package vdp_pkg;

    localparam int COMP_W = 12;
    localparam int PIX_W  = 3 * COMP_W;
    localparam int LUM_W  = 16;

    typedef enum logic [1:0] {
        BAND_LOW  = 2'd0,
        BAND_MID  = 2'd1,
        BAND_HIGH = 2'd2,
        BAND_RSV  = 2'd3
    } band_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic             blank;
        logic             csync;
        logic             vsync;
        logic             field;
        logic [PIX_W-1:0] pix;
    } vrec_t;

    localparam vrec_t REC_IDLE = '{blank: 1'b1, csync: 1'b0, vsync: 1'b0,
                                   field: 1'b0, pix: '0};

endpackage

// File: rtl/vdp_fmt_pack.sv
module vdp_fmt_pack
    import vdp_pkg::*;
(
    input  logic             lum_mode_i,
    input  logic [PIX_W-1:0] pix_i,
    input  logic             blank_i,
    input  logic             csync_i,
    input  logic             vsync_i,
    input  logic             field_i,
    input  logic             flush_i,
    output vrec_t            rec_o
);
    localparam int LSB_W = LUM_W - COMP_W;   // low luminance bits kept on blue
    localparam int TOP_W = COMP_W - LSB_W;   // copy of top bits on blue

    logic [LUM_W-1:0]  lum;
    logic [COMP_W-1:0] lum_hi;
    logic [PIX_W-1:0]  packed_pix;

    always_comb begin
        lum    = pix_i[LUM_W-1:0];
        lum_hi = lum[LUM_W-1 -: COMP_W];
        if (lum_mode_i) begin
            packed_pix = {lum_hi, lum_hi, lum[LUM_W-1 -: TOP_W], lum[LSB_W-1:0]};
        end else begin
            packed_pix = pix_i;
        end
    end

    always_comb begin
        if (flush_i) begin
            rec_o = REC_IDLE;
        end else begin
            rec_o = '{blank: blank_i, csync: csync_i, vsync: vsync_i,
                      field: field_i, pix: packed_pix};
        end
    end

endmodule

// File: rtl/vdp_band_ctrl.sv
module vdp_band_ctrl
    import vdp_pkg::*;
#(
    parameter int FLUSH_LEN = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] band_i,
    input  logic       blank_i,
    output band_e      band_o,
    output logic       flush_o
);
    localparam int CNT_W = (FLUSH_LEN > 2) ? $clog2(FLUSH_LEN) : 1;

    ctl_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    band_e            band_q, band_d;
    logic             change;

    assign change = (band_i != band_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            band_q  <= BAND_LOW;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            band_q  <= band_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        band_d  = band_q;
        unique case (state_q)
            ST_RUN: begin
                if (change) begin
                    band_d  = band_e'(band_i);
                    cnt_d   = CNT_W'(FLUSH_LEN - 2);
                    state_d = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (cnt_q == '0) begin
                    state_d = ST_RUN;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:   flush_o = change;
            ST_FLUSH: flush_o = 1'b1;
            default:  flush_o = 1'b1;
        endcase
    end

    assign band_o = band_q;

    AST_BAND_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && change) |-> blank_i);                       // R10
    AST_FLUSH_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |-> (cnt_q <= CNT_W'(FLUSH_LEN - 2)));       // R7

endmodule

// File: rtl/vdp_delay_line.sv
module vdp_delay_line
    import vdp_pkg::*;
#(
    parameter int MID_EXTRA  = 2,
    parameter int HIGH_EXTRA = 3,
    parameter int LEAD       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  band_e            band_i,
    input  vrec_t            rec_i,
    output vrec_t            s0_o,
    output vrec_t            tap_o,
    output logic [PIX_W-1:0] pix_o
);
    localparam int AGE_W = $clog2(LEAD + 1);

    vrec_t            s0_q;
    vrec_t            chain_q [HIGH_EXTRA];
    logic [PIX_W-1:0] lead_q  [LEAD];
    vrec_t            tap;
    logic [AGE_W-1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s0_q <= REC_IDLE;
        end else begin
            s0_q <= rec_i;
        end
    end

    generate
        for (genvar gi = 0; gi < HIGH_EXTRA; gi++) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[gi] <= REC_IDLE;
                end else if (gi == 0) begin
                    chain_q[gi] <= s0_q;
                end else begin
                    chain_q[gi] <= chain_q[(gi > 0) ? gi - 1 : 0];
                end
            end
        end
        for (genvar li = 0; li < LEAD; li++) begin : g_lead
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lead_q[li] <= '0;
                end else if (li == 0) begin
                    lead_q[li] <= tap.pix;
                end else begin
                    lead_q[li] <= lead_q[(li > 0) ? li - 1 : 0];
                end
            end
        end
    endgenerate

    always_comb begin
        unique case (band_i)
            BAND_LOW:           tap = s0_q;
            BAND_MID:           tap = chain_q[MID_EXTRA-1];
            BAND_HIGH, BAND_RSV: tap = chain_q[HIGH_EXTRA-1];
            default:            tap = chain_q[HIGH_EXTRA-1];
        endcase
    end

    assign s0_o  = s0_q;
    assign tap_o = tap;
    assign pix_o = lead_q[LEAD-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != AGE_W'(LEAD)) begin
            age_q <= age_q + 1'b1;
        end
    end

    generate
        if (LEAD == 3) begin : g_lag_chk
            AST_DATA_LAG: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q == AGE_W'(LEAD)) |-> (pix_o == $past(tap.pix, 3)));  // R3
        end
    endgenerate

endmodule

// File: rtl/vdp_out_fmt.sv
module vdp_out_fmt
    import vdp_pkg::*;
#(
    parameter int MID_EXTRA  = 2,
    parameter int HIGH_EXTRA = 3,
    parameter int LEAD       = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  band_i,
    input  logic        lum_mode_i,
    input  logic [35:0] pix_i,
    input  logic        blank_i,
    input  logic        csync_i,
    input  logic        vsync_i,
    input  logic        field_i,
    output logic [11:0] red_o,
    output logic [11:0] green_o,
    output logic [11:0] blue_o,
    output logic        blank_o,
    output logic        csync_o,
    output logic        vsync_o,
    output logic        field_o,
    output logic [1:0]  rsv_sel_o
);
    localparam int FLUSH_LEN = HIGH_EXTRA + LEAD + 1;

    band_e            band_q;
    logic             flush;
    vrec_t            in_rec;
    vrec_t            s0;
    vrec_t            tap;
    logic [PIX_W-1:0] pix_out;
    logic             armed_q;

    vdp_band_ctrl #(.FLUSH_LEN(FLUSH_LEN)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .band_i  (band_i),
        .blank_i (blank_i),
        .band_o  (band_q),
        .flush_o (flush)
    );

    vdp_fmt_pack u_pack (
        .lum_mode_i (lum_mode_i),
        .pix_i      (pix_i),
        .blank_i    (blank_i),
        .csync_i    (csync_i),
        .vsync_i    (vsync_i),
        .field_i    (field_i),
        .flush_i    (flush),
        .rec_o      (in_rec)
    );

    vdp_delay_line #(
        .MID_EXTRA  (MID_EXTRA),
        .HIGH_EXTRA (HIGH_EXTRA),
        .LEAD       (LEAD)
    ) u_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .band_i (band_q),
        .rec_i  (in_rec),
        .s0_o   (s0),
        .tap_o  (tap),
        .pix_o  (pix_out)
    );

    assign blank_o   = tap.blank;
    assign csync_o   = tap.csync;
    assign vsync_o   = tap.vsync;
    assign field_o   = tap.field;
    assign red_o     = pix_out[PIX_W-1 -: COMP_W];
    assign green_o   = pix_out[2*COMP_W-1 -: COMP_W];
    assign blue_o    = pix_out[COMP_W-1:0];
    assign rsv_sel_o = 2'b00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    AST_LUM_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(lum_mode_i) && !$past(flush)) |->
        (s0.pix[35:24] == $past(pix_i[15:4]) && s0.pix[23:12] == $past(pix_i[15:4]))); // R4
    AST_LUM_BLUE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(lum_mode_i) && !$past(flush)) |->
        (s0.pix[11:4] == $past(pix_i[15:8]) && s0.pix[3:0] == $past(pix_i[3:0])));     // R5
    AST_FLUSH_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(flush)) |-> (s0.blank && s0.pix == '0 && !s0.csync));       // R7

endmodule

// File: tb/test_vdp_out_fmt.sv
`timescale 1ns/1ps
module test_vdp_out_fmt;

    localparam int FLUSH_LEN = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  band_i = 2'd0;
    logic        lum_mode_i = 1'b0;
    logic [35:0] pix_i = '0;
    logic        blank_i = 1'b1;
    logic        csync_i = 1'b0;
    logic        vsync_i = 1'b0;
    logic        field_i = 1'b0;
    logic [11:0] red_o, green_o, blue_o;
    logic        blank_o, csync_o, vsync_o, field_o;
    logic [1:0]  rsv_sel_o;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural model state: record = {blank,csync,vsync,field,pix[35:0]}
    logic [39:0] hist [4];
    logic [35:0] taps [4];
    logic [1:0]  m_band = 2'd0;
    int          flush_left = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;   // 125 MHz

    vdp_out_fmt i_vdp_out_fmt (
        .clk(clk), .rst_n(rst_n), .band_i(band_i), .lum_mode_i(lum_mode_i),
        .pix_i(pix_i), .blank_i(blank_i), .csync_i(csync_i), .vsync_i(vsync_i),
        .field_i(field_i), .red_o(red_o), .green_o(green_o), .blue_o(blue_o),
        .blank_o(blank_o), .csync_o(csync_o), .vsync_o(vsync_o),
        .field_o(field_o), .rsv_sel_o(rsv_sel_o)
    );

    function automatic logic [39:0] make_rec(input logic lm, input logic [35:0] px,
                                             input logic bk, cs, vs, fd);
        logic [35:0] p;
        if (lm) p = {px[15:4], px[15:4], px[15:8], px[3:0]};   // R4 R5
        else    p = px;                                          // R1
        return {bk, cs, vs, fd, p};
    endfunction

    function automatic int extra_of(input logic [1:0] b);       // R2
        if (b == 2'd0) return 0;
        if (b == 2'd1) return 2;
        return 3;
    endfunction

    task automatic check_out(input string tag);
        logic [3:0]  exp_t;
        logic [35:0] exp_p;
        logic [39:0] t;
        t     = hist[extra_of(m_band)];
        exp_t = t[39:36];
        exp_p = taps[3];
        n_cmp++;
        if ({blank_o, csync_o, vsync_o, field_o} !== exp_t) begin
            n_bad++;
            $display("FAIL %s R2 R6 timing flags: got %b expected %b", tag,
                     {blank_o, csync_o, vsync_o, field_o}, exp_t);
        end
        n_cmp++;
        if ({red_o, green_o, blue_o} !== exp_p) begin
            n_bad++;
            $display("FAIL %s R3 lanes: got %h expected %h", tag,
                     {red_o, green_o, blue_o}, exp_p);
        end
        n_cmp++;
        if (rsv_sel_o !== 2'b00) begin
            n_bad++;
            $display("FAIL R8 reserved selects: got %b expected 00", rsv_sel_o);
        end
    endtask

    task automatic model_edge(input logic [1:0] b, input logic lm, input logic [35:0] px,
                              input logic bk, cs, vs, fd);
        logic [39:0] rec;
        if (flush_left > 0) begin                         // R7
            rec = {1'b1, 39'd0};
            flush_left--;
        end else if (b != m_band) begin
            m_band     = b;
            rec        = {1'b1, 39'd0};
            flush_left = FLUSH_LEN - 1;
        end else begin
            rec = make_rec(lm, px, bk, cs, vs, fd);
        end
        for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = rec;
        for (int i = 3; i > 0; i--) taps[i] = taps[i-1];
        taps[0] = hist[extra_of(m_band)][35:0];
    endtask

    task automatic cycle(input logic [1:0] b, input logic lm, input logic [35:0] px,
                         input logic bk, cs, vs, fd, input string tag);
        band_i = b; lum_mode_i = lm; pix_i = px;
        blank_i = bk; csync_i = cs; vsync_i = vs; field_i = fd;
        @(posedge clk);
        #1;
        model_edge(b, lm, px, bk, cs, vs, fd);
        @(negedge clk);
        check_out(tag);
    endtask

    // raster-like segment; starts on a blanked position so a band change is legal (R10)
    task automatic segment(input logic [1:0] b, input logic lm, input int ncyc,
                           input logic interlaced, input string tag);
        for (int n = 0; n < ncyc; n++) begin
            int pos;
            int line;
            pos  = n % 16;
            line = n / 16;
            seed = seed * 32'd1103515245 + 32'd12345;
            cycle(b, lm, {seed[7:4], seed}, (pos < 4), (pos < 2), (line % 4 == 0),
                  interlaced ? ((n / 64) % 2 == 1) : 1'b0, tag);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            hist[i] = {1'b1, 39'd0};
            taps[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_out("R9 reset");
        // R1 R3: colour mode, low band, progressive (field stays low, R6)
        segment(2'd0, 1'b0, 80, 1'b0, "R1 band0");
        // R7: change into mid band, active pixels during drain are dropped
        segment(2'd1, 1'b0, 80, 1'b1, "R7 R2 band1");
        segment(2'd2, 1'b0, 80, 1'b1, "R2 band2");
        segment(2'd3, 1'b0, 80, 1'b0, "R2 band3");
        // R4 R5 luminance packing in every band
        segment(2'd3, 1'b1, 48, 1'b1, "R4 band3 lum");
        segment(2'd2, 1'b1, 80, 1'b1, "R5 band2 lum");
        segment(2'd1, 1'b1, 80, 1'b0, "R4 band1 lum");
        segment(2'd0, 1'b1, 80, 1'b1, "R5 band0 lum");
        segment(2'd0, 1'b0, 64, 1'b0, "R6 band0 back to colour");
        segment(2'd2, 1'b0, 64, 1'b1, "R3 band2 again");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule